// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the register side of a simple serial port. Software reaches it over a 32-bit word-indexed register bus with separate read and write strobes. A line receiver delivers bytes through a valid/ready handshake and signals a line break with a one-cycle pulse. Each accepted write to the transmit register produces a one-cycle byte pulse toward a line transmitter. A single level interrupt combines the receive-ready and transmit-ready conditions with their enables.

Received data sits in a one-character holding buffer. Reading the receive register consumes a waiting character and frees the buffer for the next byte. Status bits track the state of that buffer, and some status bits clear when software writes a one to them. A soft reset is requested by writing a zero to the low bit of the second control register. The registers for baud rate, FIFO control and the millisecond tick only store and return the value software writes. They drive nothing.

Register word indices:

| Index | Register |
|-------|----------|
| 0x00 | receive data |
| 0x10 | transmit data |
| 0x20 | control1 |
| 0x21 | control2 |
| 0x22 | control3 |
| 0x23 | control4 |
| 0x24 | FIFO control |
| 0x25 | status1 |
| 0x26 | status2 |
| 0x29 | baud increment |
| 0x2A | baud modulator |
| 0x2B | baud count |
| 0x2C | millisecond |
| 0x2D | test |

Top module: `uart_regfront`

## Requirements
- R1: After reset the registers read as follows: status1 = 0x6040, status2 = 0x4028, test = 0x0060, control1 = 0, control2 = 0x0001, control3 = 0x0700, modulator = 0, baud count = 4, FIFO control = 0 and millisecond = 0. Receive data reads 0x4000.
- R2: When status1 bit 9 (rx-ready) is clear, `rx_ready` is high. A byte offered with `rx_valid` in that state is stored and sets status1 bit 9 and status2 bit 0. It also clears test bit 5 (rx-empty). While status1 bit 9 is set, `rx_ready` is low and an offered byte is dropped.
- R3: A read of receive data returns the buffered 16-bit value. If test bit 5 is clear, the read also sets bit 15 of the returned word, clears status1 bit 9 and status2 bit 0, and sets test bit 5. If test bit 5 is set, the read returns the buffer without bit 15 and changes no state.
- R4: A `rx_break` pulse loads the buffer with 0x0800 and sets the ready flags exactly as a byte does. It is taken even when the buffer is full. It also wins over a byte offered in the same cycle.
- R5: A write to the transmit register while control2 bit 2 is set drives `tx_valid` high for one cycle, in the cycle after the write, with `tx_data` equal to the low 8 bits of the write data. When control2 bit 2 is clear, the write has no effect.
- R6: `irq` is high exactly when (status1 bit 9 AND control1 bit 9) or (status1 bit 13 AND control1 bit 13 AND control1 bit 6).
- R7: A write to control2 with bit 0 equal to 0 returns every register and the receive buffer to its R1 value. Control2 then stores the written low 16 bits with bit 0 forced to 1. Control2 bit 0 therefore always reads 1.
- R8: Status writes clear only the write-one-to-clear bits: status1 bits 15, 12, 11, 10, 8, 7, 5, 4 and status2 bits 15, 13, 12, 11, 10, 8, 7, 6, 4, 2, 1. Ones written to any other status bit, including the rx-ready and tx-ready bits, have no effect.
- R9: Writes to control1, control2, control3, FIFO control, baud modulator and millisecond store the low 16 bits. A write to index 0x29 stores the baud count, which reads back at 0x2B. Index 0x29 reads zero. Control4 (0x23) reads zero and ignores writes. The test register ignores writes.
- R10: Unmapped indices read as zero, and writes to them have no effect.
- R11: `bus_rdata` is registered. It presents the selected register in the cycle after `bus_rd` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| bus_rd | input | 1 | read strobe |
| bus_wr | input | 1 | write strobe |
| bus_idx | input | 6 | register word index |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, registered |
| rx_valid | input | 1 | receive byte offered |
| rx_data | input | 8 | received byte |
| rx_ready | output | 1 | receive buffer can take a byte |
| rx_break | input | 1 | line break event pulse |
| tx_valid | output | 1 | one-cycle transmit byte pulse |
| tx_data | output | 8 | transmit byte |
| irq | output | 1 | level interrupt |

## Verification
The assertions check on every cycle that the three receive flags in status1, status2 and the test register agree with each other. They also check the following:
- A handshake, a break or a consuming read moves those flags the following cycle.
- A transmit pulse is always traced back to an enabled write.
- Control2 bit 0 stays set, and a soft reset clears control1 and the receive flag.
- A status write leaves the rx-ready bit unchanged.

Only the bench scenarios can show the data values:
- the returned character with its valid bit;
- the break code and its priority;
- the exact reset values;
- the 16-bit masking and the baud-count alias;
- the full truth table of the interrupt.

// File: rtl/uart_regfront_pkg.sv
// Package: shared widths, register indices, bit positions and reset values
// for the serial port register front end.
package uart_regfront_pkg;

    localparam int IDX_W  = 6;
    localparam int DATA_W = 32;
    localparam int REG_W  = 16;
    localparam int BYTE_W = 8;

    // Word indices of the register map
    localparam logic [IDX_W-1:0] IDX_RXD  = 6'h00;
    localparam logic [IDX_W-1:0] IDX_TXD  = 6'h10;
    localparam logic [IDX_W-1:0] IDX_CTL1 = 6'h20;
    localparam logic [IDX_W-1:0] IDX_CTL2 = 6'h21;
    localparam logic [IDX_W-1:0] IDX_CTL3 = 6'h22;
    localparam logic [IDX_W-1:0] IDX_CTL4 = 6'h23;
    localparam logic [IDX_W-1:0] IDX_FIFO = 6'h24;
    localparam logic [IDX_W-1:0] IDX_STS1 = 6'h25;
    localparam logic [IDX_W-1:0] IDX_STS2 = 6'h26;
    localparam logic [IDX_W-1:0] IDX_BINC = 6'h29;
    localparam logic [IDX_W-1:0] IDX_BMOD = 6'h2A;
    localparam logic [IDX_W-1:0] IDX_BCNT = 6'h2B;
    localparam logic [IDX_W-1:0] IDX_MSEC = 6'h2C;
    localparam logic [IDX_W-1:0] IDX_TEST = 6'h2D;

    // Bit positions the logic depends on
    localparam int S1_RXRDY   = 9;
    localparam int S1_TXRDY   = 13;
    localparam int S2_DRDY    = 0;
    localparam int T_RXEMPTY  = 5;
    localparam int C1_RXIE    = 9;
    localparam int C1_TXIE    = 13;
    localparam int C1_TXMTIE  = 6;
    localparam int C2_NSRST   = 0;
    localparam int C2_TXEN    = 2;
    localparam int RB_VALID   = 15;

    // Status and receive-buffer reset values and clearable masks
    localparam logic [REG_W-1:0] STS1_RST   = 16'h6040;
    localparam logic [REG_W-1:0] STS2_RST   = 16'h4028;
    localparam logic [REG_W-1:0] TEST_RST   = 16'h0060;
    localparam logic [REG_W-1:0] STS1_W1C   = 16'h9DB0;
    localparam logic [REG_W-1:0] STS2_W1C   = 16'hBDD6;
    localparam logic [REG_W-1:0] TEST_W1C   = 16'h0000;
    localparam logic [REG_W-1:0] RXBUF_RST  = 16'h4000;
    localparam logic [REG_W-1:0] RXBUF_BRK  = 16'h0800;

    // Plain storage registers: write index, read index, reset value and
    // bits forced to one on every write
    localparam int NCFG    = 7;
    localparam int CFG_C1  = 0;
    localparam int CFG_C2  = 1;
    localparam logic [IDX_W-1:0] CFG_WIDX [NCFG] =
        '{IDX_CTL1, IDX_CTL2, IDX_CTL3, IDX_FIFO, IDX_BMOD, IDX_BINC, IDX_MSEC};
    localparam logic [IDX_W-1:0] CFG_RIDX [NCFG] =
        '{IDX_CTL1, IDX_CTL2, IDX_CTL3, IDX_FIFO, IDX_BMOD, IDX_BCNT, IDX_MSEC};
    localparam logic [REG_W-1:0] CFG_RST  [NCFG] =
        '{16'h0000, 16'h0001, 16'h0700, 16'h0000, 16'h0000, 16'h0004, 16'h0000};
    localparam logic [REG_W-1:0] CFG_FORCE[NCFG] =
        '{16'h0000, 16'h0001, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000};

endpackage

// File: rtl/uart_cfg_reg.sv
// Module: one 16-bit storage register.
// Loads the written value, with the FORCE_SET bits ORed in, when a write hits
// WIDX. Returns to RST_VAL on hard reset, and on soft reset when it is not
// being written in that same cycle.
// Assumes: the caller qualifies wr_en with the write strobe.
module uart_cfg_reg #(
    parameter int                REG_W     = 16,
    parameter int                IDX_W     = 6,
    parameter logic [REG_W-1:0]  RST_VAL   = '0,
    parameter logic [REG_W-1:0]  FORCE_SET = '0,
    parameter logic [IDX_W-1:0]  WIDX      = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [REG_W-1:0] wr_data,
    input  logic             soft_rst,
    output logic [REG_W-1:0] q
);

    logic hit;
    assign hit = wr_en && (wr_idx == WIDX);

    // Storage update: write beats soft reset, soft reset beats hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (hit) begin
            q <= wr_data | FORCE_SET;
        end else if (soft_rst) begin
            q <= RST_VAL;
        end
    end

endmodule

// File: rtl/uart_sts_reg.sv
// Module: status register with write-one-to-clear bits and hardware set and
// clear inputs.
// Ones written in W1C_MASK clear bits. Ones on hw_set win over a clear in the
// same cycle. Soft reset restores RST_VAL.
// Assumes: the caller never asserts hw_set and hw_clr on the same bit together.
module uart_sts_reg #(
    parameter int               REG_W    = 16,
    parameter logic [REG_W-1:0] RST_VAL  = '0,
    parameter logic [REG_W-1:0] W1C_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [REG_W-1:0] hw_set,
    input  logic [REG_W-1:0] hw_clr,
    output logic [REG_W-1:0] q
);

    logic [REG_W-1:0] sw_clr;
    logic [REG_W-1:0] nxt;

    // Next value: software and hardware clears first, then hardware sets
    always_comb begin
        sw_clr = wr_en ? (wr_data & W1C_MASK) : '0;
        nxt    = (q & ~sw_clr & ~hw_clr) | hw_set;
    end

    // State update with hard and soft reset
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            q <= RST_VAL;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/uart_rx_hold.sv
// Module: one-character receive holding buffer.
// A break loads the break code. Otherwise an accepted byte loads the byte,
// zero-extended. Soft reset restores the error-only value.
// Assumes: the caller has already applied the ready gating to load_byte.
module uart_rx_hold #(
    parameter int               REG_W   = 16,
    parameter int               BYTE_W  = 8,
    parameter logic [REG_W-1:0] RST_VAL = '0,
    parameter logic [REG_W-1:0] BRK_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              load_byte,
    input  logic              load_break,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [REG_W-1:0]  buf_q
);

    localparam int PAD_W = REG_W - BYTE_W;

    // Buffer update, with priority soft reset > break > byte
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            buf_q <= RST_VAL;
        end else if (load_break) begin
            buf_q <= BRK_VAL;
        end else if (load_byte) begin
            buf_q <= {{PAD_W{1'b0}}, byte_in};
        end
    end

endmodule

// File: rtl/uart_regfront.sv
// Module: serial port register front end (top).
// Decodes the word-indexed register bus, holds the control, status and test
// registers, the one-character receive buffer and the transmit pulse, and
// combines the interrupt.
// Assumes: single-cycle strobes, and rx_break is a one-cycle pulse.
module uart_regfront
    import uart_regfront_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [IDX_W-1:0]  bus_idx,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    input  logic              rx_break,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              irq
);

    localparam int HI_W = DATA_W - REG_W;

    logic [REG_W-1:0]  wr_lo;
    logic              unused_wdata_hi;
    logic              soft_rst;
    logic              rx_full;
    logic              load_byte;
    logic              load_any;
    logic              take;
    logic              take_eff;
    logic [REG_W-1:0]  sts1_q, sts2_q, test_q, rxbuf_q;
    logic [REG_W-1:0]  s1_set, s1_clr, s2_set, s2_clr, t_set, t_clr;
    logic [REG_W-1:0]  cfg_q [NCFG];
    logic [DATA_W-1:0] rd_val;

    assign wr_lo           = bus_wdata[REG_W-1:0];
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:REG_W];

    // Control decode: soft reset, receive acceptance and consuming read
    always_comb begin
        soft_rst  = bus_wr && (bus_idx == IDX_CTL2) && !bus_wdata[C2_NSRST];
        rx_full   = sts1_q[S1_RXRDY];
        load_byte = rx_valid && !rx_full && !rx_break;
        load_any  = load_byte || rx_break;
        take      = bus_rd && (bus_idx == IDX_RXD) && !test_q[T_RXEMPTY];
        take_eff  = take && !load_any;
    end

    // Hardware set/clear vectors for the three receive flags
    always_comb begin
        s1_set = '0; s1_clr = '0;
        s2_set = '0; s2_clr = '0;
        t_set  = '0; t_clr  = '0;
        s1_set[S1_RXRDY]  = load_any;
        s1_clr[S1_RXRDY]  = take_eff;
        s2_set[S2_DRDY]   = load_any;
        s2_clr[S2_DRDY]   = take_eff;
        t_set[T_RXEMPTY]  = take_eff;
        t_clr[T_RXEMPTY]  = load_any;
    end

    uart_sts_reg #(.REG_W(REG_W), .RST_VAL(STS1_RST), .W1C_MASK(STS1_W1C)) u_sts1 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .wr_en(bus_wr && (bus_idx == IDX_STS1)), .wr_data(wr_lo),
        .hw_set(s1_set), .hw_clr(s1_clr), .q(sts1_q)
    );

    uart_sts_reg #(.REG_W(REG_W), .RST_VAL(STS2_RST), .W1C_MASK(STS2_W1C)) u_sts2 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .wr_en(bus_wr && (bus_idx == IDX_STS2)), .wr_data(wr_lo),
        .hw_set(s2_set), .hw_clr(s2_clr), .q(sts2_q)
    );

    uart_sts_reg #(.REG_W(REG_W), .RST_VAL(TEST_RST), .W1C_MASK(TEST_W1C)) u_test (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .wr_en(bus_wr && (bus_idx == IDX_TEST)), .wr_data(wr_lo),
        .hw_set(t_set), .hw_clr(t_clr), .q(test_q)
    );

    uart_rx_hold #(.REG_W(REG_W), .BYTE_W(BYTE_W), .RST_VAL(RXBUF_RST),
                   .BRK_VAL(RXBUF_BRK)) u_rxbuf (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .load_byte(load_byte), .load_break(rx_break),
        .byte_in(rx_data), .buf_q(rxbuf_q)
    );

    // Plain storage registers, one instance per table slot
    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
        uart_cfg_reg #(
            .REG_W(REG_W), .IDX_W(IDX_W), .RST_VAL(CFG_RST[g]),
            .FORCE_SET(CFG_FORCE[g]), .WIDX(CFG_WIDX[g])
        ) u_reg (
            .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_idx(bus_idx),
            .wr_data(wr_lo), .soft_rst(soft_rst), .q(cfg_q[g])
        );
    end

    // Read multiplexer over all readable indices
    always_comb begin
        rd_val = '0;
        case (bus_idx)
            IDX_RXD: begin
                rd_val[REG_W-1:0]  = rxbuf_q;
                rd_val[RB_VALID]   = !test_q[T_RXEMPTY];
            end
            IDX_STS1: rd_val[REG_W-1:0] = sts1_q;
            IDX_STS2: rd_val[REG_W-1:0] = sts2_q;
            IDX_TEST: rd_val[REG_W-1:0] = test_q;
            default:  rd_val = '0;
        endcase
        for (int k = 0; k < NCFG; k++) begin
            if (bus_idx == CFG_RIDX[k]) begin
                rd_val = {{HI_W{1'b0}}, cfg_q[k]};
            end
        end
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_val;
        end
    end

    // Transmit pulse on an enabled write to the transmit index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= bus_wr && (bus_idx == IDX_TXD) && cfg_q[CFG_C2][C2_TXEN];
            if (bus_wr && (bus_idx == IDX_TXD)) begin
                tx_data <= bus_wdata[BYTE_W-1:0];
            end
        end
    end

    // Handshake ready and interrupt combining
    assign rx_ready = !rx_full;
    assign irq = (sts1_q[S1_RXRDY] && cfg_q[CFG_C1][C1_RXIE]) ||
                 (sts1_q[S1_TXRDY] && cfg_q[CFG_C1][C1_TXIE] &&
                  cfg_q[CFG_C1][C1_TXMTIE]);

endmodule

// File: rtl/uart_regfront_chk.sv
// Module: assertion checker bound into uart_regfront.
// Watches the bus, the handshake and the internal register outputs.
module uart_regfront_chk
    import uart_regfront_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [IDX_W-1:0]  bus_idx,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              rx_break,
    input logic              tx_valid,
    input logic              irq,
    input logic [REG_W-1:0]  sts1,
    input logic [REG_W-1:0]  sts2,
    input logic [REG_W-1:0]  test,
    input logic [REG_W-1:0]  ctl1,
    input logic [REG_W-1:0]  ctl2
);

    logic srst;
    assign srst = bus_wr && (bus_idx == IDX_CTL2) && !bus_wdata[C2_NSRST];

    assert_flags_agree_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sts1[S1_RXRDY] == sts2[S2_DRDY]) && (sts1[S1_RXRDY] == !test[T_RXEMPTY]));

    assert_accept_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && !srst) |=> sts1[S1_RXRDY]);

    assert_take_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_idx == IDX_RXD && !test[T_RXEMPTY] && !rx_break && !srst)
        |=> (!sts1[S1_RXRDY] && test[T_RXEMPTY]));

    assert_break_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_break && !srst) |=> sts1[S1_RXRDY]);

    assert_tx_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(bus_wr && bus_idx == IDX_TXD && ctl2[C2_TXEN]));

    assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl1[C1_RXIE] && !ctl1[C1_TXMTIE]) |-> !irq);

    assert_soft_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (ctl1 == '0 && !sts1[S1_RXRDY] && test[T_RXEMPTY]));

    assert_ctl2_lsb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl2[C2_NSRST]);

    assert_sts_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_idx == IDX_STS1 || bus_idx == IDX_STS2) && !bus_rd &&
         !rx_break && !(rx_valid && rx_ready))
        |=> (sts1[S1_RXRDY] == $past(sts1[S1_RXRDY])) && sts1[S1_TXRDY]);

endmodule

bind uart_regfront uart_regfront_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_break(rx_break), .tx_valid(tx_valid), .irq(irq),
    .sts1(sts1_q), .sts2(sts2_q), .test(test_q),
    .ctl1(cfg_q[uart_regfront_pkg::CFG_C1]), .ctl2(cfg_q[uart_regfront_pkg::CFG_C2])
);

// File: tb/uart_regfront_test.sv
// Bench: table-driven register round trips, then directed scenarios.
module uart_regfront_test;
    import uart_regfront_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              bus_rd, bus_wr;
    logic [IDX_W-1:0]  bus_idx;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata;
    logic              rx_valid, rx_ready, rx_break;
    logic [BYTE_W-1:0] rx_data;
    logic              tx_valid;
    logic [BYTE_W-1:0] tx_data;
    logic              irq;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    logic              tx_seen;
    logic [BYTE_W-1:0] tx_byte;

    uart_regfront uut (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .rx_break(rx_break), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [IDX_W-1:0]  widx;
        logic [DATA_W-1:0] wdata;
        logic [IDX_W-1:0]  ridx;
        logic [DATA_W-1:0] exp;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{6'h20, 32'hABCD1234, 6'h20, 32'h00001234},  // R9 control1
        '{6'h22, 32'h12345678, 6'h22, 32'h00005678},  // R9 control3
        '{6'h24, 32'hFFFFFFFF, 6'h24, 32'h0000FFFF},  // R9 FIFO control
        '{6'h2A, 32'h000100AA, 6'h2A, 32'h000000AA},  // R9 modulator
        '{6'h29, 32'h00010055, 6'h2B, 32'h00000055},  // R9 count alias
        '{6'h29, 32'h00000077, 6'h29, 32'h00000000},  // R9 increment reads 0
        '{6'h2C, 32'hCAFE03E8, 6'h2C, 32'h000003E8},  // R9 millisecond
        '{6'h23, 32'h0000FFFF, 6'h23, 32'h00000000},  // R9 control4
        '{6'h2D, 32'h0000FFFF, 6'h2D, 32'h00000060},  // R9 test ignores writes
        '{6'h3F, 32'h0000FFFF, 6'h3F, 32'h00000000},  // R10 unmapped
        '{6'h25, 32'h0000FFFF, 6'h25, 32'h00006040},  // R8 status1
        '{6'h26, 32'h0000FFFF, 6'h26, 32'h00004028},  // R8 status2
        '{6'h21, 32'h00000007, 6'h21, 32'h00000007}   // R9 control2, tx enable
    };

    task automatic check(input string req, input string what,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [IDX_W-1:0] idx, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_idx = idx; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        tx_seen = tx_valid;
        tx_byte = tx_data;
    endtask

    task automatic bus_read(input logic [IDX_W-1:0] idx, output logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_idx = idx;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_check(input string req, input string what,
                            input logic [IDX_W-1:0] idx, input logic [DATA_W-1:0] exp);
        logic [DATA_W-1:0] v;
        bus_read(idx, v);
        check(req, what, v, exp);
    endtask

    task automatic send(input logic [BYTE_W-1:0] b, input logic brk);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b; rx_break = brk;
        @(negedge clk);
        rx_valid = 1'b0; rx_break = 1'b0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] v;
        rst_n = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_idx = '0; bus_wdata = '0;
        rx_valid = 1'b0; rx_data = '0; rx_break = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values, R11 rdata cleared
        check("R11", "rdata after reset", bus_rdata, 32'h0);
        check("R2", "rx_ready after reset", {31'b0, rx_ready}, 32'h1);
        check("R6", "irq after reset", {31'b0, irq}, 32'h0);
        rd_check("R1", "status1", IDX_STS1, 32'h6040);
        rd_check("R1", "status2", IDX_STS2, 32'h4028);
        rd_check("R1", "test", IDX_TEST, 32'h0060);
        rd_check("R1", "control1", IDX_CTL1, 32'h0);
        rd_check("R1", "control2", IDX_CTL2, 32'h1);
        rd_check("R1", "control3", IDX_CTL3, 32'h0700);
        rd_check("R1", "modulator", IDX_BMOD, 32'h0);
        rd_check("R1", "baud count", IDX_BCNT, 32'h4);
        rd_check("R1", "FIFO control", IDX_FIFO, 32'h0);
        rd_check("R1", "millisecond", IDX_MSEC, 32'h0);
        rd_check("R1", "rx data empty", IDX_RXD, 32'h4000);
        rd_check("R10", "unmapped 0x05", 6'h05, 32'h0);

        // Table walk: write, then read back
        for (int i = 0; i < NVEC; i++) begin
            bus_write(VECS[i].widx, VECS[i].wdata);
            bus_read(VECS[i].ridx, v);
            if (VECS[i].ridx == IDX_STS1 || VECS[i].ridx == IDX_STS2)
                check("R8", $sformatf("vector %0d", i), v, VECS[i].exp);
            else if (VECS[i].ridx == 6'h3F)
                check("R10", $sformatf("vector %0d", i), v, VECS[i].exp);
            else
                check("R9", $sformatf("vector %0d", i), v, VECS[i].exp);
        end

        // R11 rdata holds through idle cycles and writes
        bus_read(IDX_CTL3, v);
        repeat (3) @(negedge clk);
        bus_write(IDX_CTL3, 32'h0000_1111);
        check("R11", "rdata held", bus_rdata, 32'h5678);

        // R5 transmit enabled (control2 = 7)
        bus_write(IDX_TXD, 32'h0000_01A5);
        check("R5", "tx_valid on enabled write", {31'b0, tx_seen}, 32'h1);
        check("R5", "tx_data low byte", {24'b0, tx_byte}, 32'hA5);
        @(negedge clk);
        check("R5", "tx pulse one cycle", {31'b0, tx_valid}, 32'h0);
        bus_write(IDX_CTL2, 32'h0000_0003);
        bus_write(IDX_TXD, 32'h0000_003C);
        check("R5", "tx blocked when disabled", {31'b0, tx_seen}, 32'h0);

        // R2 receive acceptance, drop while full
        send(8'h5C, 1'b0);
        check("R2", "rx_ready low when full", {31'b0, rx_ready}, 32'h0);
        rd_check("R2", "status1 full", IDX_STS1, 32'h6240);
        rd_check("R2", "status2 full", IDX_STS2, 32'h4029);
        rd_check("R2", "test full", IDX_TEST, 32'h0040);
        send(8'h11, 1'b0);
        // R3 consuming read, then non-consuming read
        rd_check("R3", "rx data valid", IDX_RXD, 32'h805C);
        rd_check("R3", "rx data again", IDX_RXD, 32'h005C);
        rd_check("R3", "status1 emptied", IDX_STS1, 32'h6040);
        rd_check("R3", "test emptied", IDX_TEST, 32'h0060);

        // R8 status writes keep the rx-ready flags
        send(8'h33, 1'b0);
        bus_write(IDX_STS1, 32'h0000_FFFF);
        bus_write(IDX_STS2, 32'h0000_FFFF);
        rd_check("R8", "status1 kept", IDX_STS1, 32'h6240);
        rd_check("R8", "status2 kept", IDX_STS2, 32'h4029);
        rd_check("R8", "char kept", IDX_RXD, 32'h8033);

        // R4 break priority and break while full
        send(8'h77, 1'b1);
        rd_check("R4", "break beats byte", IDX_RXD, 32'h8800);
        send(8'h44, 1'b0);
        send(8'h00, 1'b1);
        rd_check("R4", "break when full", IDX_RXD, 32'h8800);

        // R6 interrupt combinations
        bus_write(IDX_CTL1, 32'h0000_0200);
        check("R6", "rx enable, empty", {31'b0, irq}, 32'h0);
        send(8'h12, 1'b0);
        check("R6", "rx enable, full", {31'b0, irq}, 32'h1);
        bus_read(IDX_RXD, v);
        check("R6", "rx consumed", {31'b0, irq}, 32'h0);
        bus_write(IDX_CTL1, 32'h0000_2000);
        check("R6", "tx enable without empty enable", {31'b0, irq}, 32'h0);
        bus_write(IDX_CTL1, 32'h0000_2040);
        check("R6", "tx enable with empty enable", {31'b0, irq}, 32'h1);
        bus_write(IDX_CTL1, 32'h0000_0040);
        check("R6", "empty enable alone", {31'b0, irq}, 32'h0);

        // R7 soft reset
        bus_write(IDX_CTL1, 32'h0000_0200);
        bus_write(IDX_CTL3, 32'h0000_2222);
        bus_write(IDX_BINC, 32'h0000_0099);
        send(8'h66, 1'b0);
        bus_write(IDX_CTL2, 32'h0000_0006);
        check("R7", "rx_ready after soft reset", {31'b0, rx_ready}, 32'h1);
        check("R7", "irq after soft reset", {31'b0, irq}, 32'h0);
        rd_check("R7", "control2 forced", IDX_CTL2, 32'h0007);
        rd_check("R7", "control1", IDX_CTL1, 32'h0);
        rd_check("R7", "control3", IDX_CTL3, 32'h0700);
        rd_check("R7", "baud count", IDX_BCNT, 32'h4);
        rd_check("R7", "status1", IDX_STS1, 32'h6040);
        rd_check("R7", "test", IDX_TEST, 32'h0060);
        rd_check("R7", "rx data", IDX_RXD, 32'h4000);
        bus_write(IDX_TXD, 32'h0000_00C3);
        check("R7", "tx enabled from stored value", {24'b0, tx_byte}, 32'hC3);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule